// File: doc/BRIEF.md
# Reconfigurable Parallel LFSR Engine

This block is a linear feedback shift register for keystream generation whose length and feedback taps are chosen at run time rather than fixed in hardware. A single structure can therefore stand in for the linear registers of several different stream ciphers. Software-facing logic elsewhere programs a tap mask and an active length, loads a starting state, and then raises an enable. Each enabled clock advances the register by a whole batch of shift steps.

The feedback is Fibonacci style. The feedback bit is the XOR of every state bit selected by the tap mask. That bit enters at the top of the active region while the register shifts toward bit 0. The batch of steps is unrolled in combinational logic, so each step sees the state left by the step before it. The bits shifted out during the batch are returned as one parallel word, with the earliest step in the lowest bit.

Top module: `lfsr_par_engine`

## Requirements
- R1: After reset the state and the tap mask are all zero, the active length is MAX_LEN (256), and `outWord` is zero.
- R2: When `cfgWe` is high and `enable` is low, the active length becomes `cfgLen` clamped into 2..MAX_LEN, and the tap mask becomes `cfgTaps` with the bits at index length and above cleared. When `cfgWe` is high and `enable` is high, the configuration is ignored.
- R3: When `seedWe` is high, the state becomes `seedData` with the bits at index length and above cleared. If `cfgWe` is accepted in the same cycle, the new length applies to the seed.
- R4: When `seedWe` and `enable` are high in the same cycle, the seed is loaded, no shift step is taken, and `outWord` keeps its previous value.
- R5: One step works as follows. The feedback is the XOR of (state AND tap mask). State bit 0 is the bit shifted out. Every bit moves down one index, and the feedback enters at bit length-1.
- R6: Each cycle with `enable` high and `seedWe` low performs PAR (32) chained steps. Step k operates on the state produced by step k-1.
- R7: Bit k of `outWord` is the bit shifted out by step k (bit 0 is the earliest step). It is registered on the enabled edge and held at all other times.
- R8: In a cycle with no accepted configuration, seed or step, the state does not change.
- R9: An all-zero seed is accepted, the state stays all zero while stepping, and `outWord` is zero. No error is indicated.
- R10: State bits at index length and above are always zero. A configuration write that shortens the register clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Commit one parallel update of PAR steps |
| cfgWe | input | 1 | Configuration write strobe, honoured only while `enable` is low |
| cfgLen | input | 9 | Requested active length, clamped into 2..256 |
| cfgTaps | input | 256 | Feedback tap mask; bit i selects state bit i |
| seedWe | input | 1 | Seed load strobe; has priority over an update |
| seedData | input | 256 | Initial state value |
| outWord | output | 32 | Bits shifted out by the last update, earliest in bit 0 |

## Verification
Two pairs of actions can land in the same cycle. A seed load can coincide with an enabled update, and a configuration write can coincide with `enable` or with a seed load. The bench drives each pair together on purpose. A seed that arrives with `enable` must leave `outWord` unchanged in that cycle, and the following updates must match the reference started from that seed. A configuration presented during `enable` must have no effect, which shows when later updates still follow the old taps and length. Each update is judged against a bench model that steps the register one bit at a time, 32 times per enabled cycle.

// File: rtl/lfsr_par_pkg.sv
package lfsr_par_pkg;

  localparam int DEF_MAX_LEN = 256;
  localparam int DEF_PAR     = 32;

  typedef struct packed {
    logic loadCfg;
    logic loadSeed;
    logic doStep;
  } lfsr_strobe_t;

endpackage

// File: rtl/lfsr_par_ctrl.sv
module lfsr_par_ctrl
  import lfsr_par_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         cfgWe,
  input  logic         seedWe,
  output lfsr_strobe_t strb
);

  always_comb begin
    strb.loadSeed = seedWe;
    strb.doStep   = enable && !seedWe;
    strb.loadCfg  = cfgWe && !enable;
  end

  // R2: configuration never accepted while an update is requested
  a_r2_cfg_blocked: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> !strb.loadCfg);

  // R4: seed and step never both issued
  a_r4_seed_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadSeed, strb.doStep}));

  // R4: seed request always wins over an update
  a_r4_seed_priority: assert property (@(posedge clk) disable iff (!rstN)
    (seedWe && enable) |-> (strb.loadSeed && !strb.doStep));

endmodule

// File: rtl/lfsr_par_unroll.sv
module lfsr_par_unroll #(
  parameter int MAX_LEN = 256,
  parameter int PAR     = 32
) (
  input  logic [MAX_LEN-1:0] stateIn,
  input  logic [MAX_LEN-1:0] taps,
  input  logic [MAX_LEN-1:0] topBit,
  output logic [MAX_LEN-1:0] stateOut,
  output logic [PAR-1:0]     bitsOut
);

  logic [PAR:0][MAX_LEN-1:0] stage;

  assign stage[0] = stateIn;

  for (genvar k = 0; k < PAR; k++) begin : g_step
    logic fbBit;
    assign fbBit        = ^(stage[k] & taps);
    assign bitsOut[k]   = stage[k][0];
    assign stage[k+1]   = (stage[k] >> 1) | (fbBit ? topBit : '0);
  end

  assign stateOut = stage[PAR];

endmodule

// File: rtl/lfsr_par_datapath.sv
module lfsr_par_datapath
  import lfsr_par_pkg::*;
#(
  parameter int MAX_LEN = 256,
  parameter int PAR     = 32,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  lfsr_strobe_t       strb,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic [MAX_LEN-1:0] cfgTaps,
  input  logic [MAX_LEN-1:0] seedData,
  output logic [PAR-1:0]     outWord
);

  logic [LEN_W-1:0]   lenQ;
  logic [MAX_LEN-1:0] lenMaskQ;
  logic [MAX_LEN-1:0] topQ;
  logic [MAX_LEN-1:0] tapsQ;
  logic [MAX_LEN-1:0] stateQ;
  logic [PAR-1:0]     outQ;

  logic [LEN_W-1:0]   effLen;
  logic [MAX_LEN-1:0] effMask;
  logic [MAX_LEN-1:0] effTop;
  logic [MAX_LEN-1:0] stepState;
  logic [PAR-1:0]     stepBits;

  function automatic logic [LEN_W-1:0] clampLen(input logic [LEN_W-1:0] v);
    if (int'(v) < 2)            return LEN_W'(2);
    else if (int'(v) > MAX_LEN) return LEN_W'(MAX_LEN);
    else                        return v;
  endfunction

  function automatic logic [MAX_LEN-1:0] maskFor(input logic [LEN_W-1:0] len);
    logic [MAX_LEN-1:0] m;
    for (int i = 0; i < MAX_LEN; i++) m[i] = (i < int'(len));
    return m;
  endfunction

  always_comb begin
    effLen  = strb.loadCfg ? clampLen(cfgLen) : lenQ;
    effMask = strb.loadCfg ? maskFor(effLen) : lenMaskQ;
    effTop  = MAX_LEN'(1) << (effLen - LEN_W'(1));
  end

  lfsr_par_unroll #(
    .MAX_LEN(MAX_LEN),
    .PAR    (PAR)
  ) u_unroll (
    .stateIn (stateQ),
    .taps    (tapsQ),
    .topBit  (topQ),
    .stateOut(stepState),
    .bitsOut (stepBits)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ     <= LEN_W'(MAX_LEN);
      lenMaskQ <= '1;
      topQ     <= MAX_LEN'(1) << (MAX_LEN - 1);
      tapsQ    <= '0;
      stateQ   <= '0;
      outQ     <= '0;
    end else begin
      if (strb.loadCfg) begin
        lenQ     <= effLen;
        lenMaskQ <= effMask;
        topQ     <= effTop;
        tapsQ    <= cfgTaps & effMask;
      end
      if (strb.loadSeed) begin
        stateQ <= seedData & effMask;
      end else if (strb.doStep) begin
        stateQ <= stepState;
        outQ   <= stepBits;
      end else if (strb.loadCfg) begin
        stateQ <= stateQ & effMask;
      end
    end
  end

  assign outWord = outQ;

  // R10: nothing lives above the active length
  a_r10_zero_above_len: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ & ~lenMaskQ) == '0);

  // R2: stored taps confined to the active region, length within range
  a_r2_taps_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ((tapsQ & ~lenMaskQ) == '0) && (int'(lenQ) >= 2) && (int'(lenQ) <= MAX_LEN));

  // R3: seed lands in the state on the next edge
  a_r3_seed_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadSeed |=> stateQ == $past(seedData & effMask));

  // R8: state holds when nothing is accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadSeed && !strb.doStep && !strb.loadCfg) |=> $stable(stateQ));

  // R7: output word held when no step
  a_r7_out_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doStep |=> $stable(outWord));

  // R7: first output bit is the old bit 0
  a_r7_first_bit: assert property (@(posedge clk) disable iff (!rstN)
    strb.doStep |=> outWord[0] == $past(stateQ[0]));

  // R9: all-zero state is a fixed point
  a_r9_zero_stays: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doStep && stateQ == '0) |=> (stateQ == '0 && outWord == '0));

endmodule

// File: rtl/lfsr_par_engine.sv
module lfsr_par_engine
  import lfsr_par_pkg::*;
#(
  parameter int MAX_LEN = DEF_MAX_LEN,
  parameter int PAR     = DEF_PAR,
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               cfgWe,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic [MAX_LEN-1:0] cfgTaps,
  input  logic               seedWe,
  input  logic [MAX_LEN-1:0] seedData,
  output logic [PAR-1:0]     outWord
);

  lfsr_strobe_t strb;

  lfsr_par_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .enable(enable),
    .cfgWe (cfgWe),
    .seedWe(seedWe),
    .strb  (strb)
  );

  lfsr_par_datapath #(
    .MAX_LEN(MAX_LEN),
    .PAR    (PAR)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgLen  (cfgLen),
    .cfgTaps (cfgTaps),
    .seedData(seedData),
    .outWord (outWord)
  );

endmodule

// File: tb/sim_lfsr_par_engine.sv
`timescale 1ns/1ps
module sim_lfsr_par_engine;

  localparam int ML = 256;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic          cfgWe = 1'b0;
  logic [8:0]    cfgLen = '0;
  logic [ML-1:0] cfgTaps = '0;
  logic          seedWe = 1'b0;
  logic [ML-1:0] seedData = '0;
  logic [NP-1:0] outWord;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  // behavioural reference
  logic [ML-1:0] mState = '0;
  logic [ML-1:0] mTaps = '0;
  int            mLen = ML;
  logic [NP-1:0] mOut = '0;

  always #2 clk = ~clk;

  lfsr_par_engine u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWe(cfgWe), .cfgLen(cfgLen),
    .cfgTaps(cfgTaps), .seedWe(seedWe), .seedData(seedData), .outWord(outWord)
  );

  function automatic logic [ML-1:0] rand256();
    logic [ML-1:0] r;
    for (int i = 0; i < ML/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [ML-1:0] lowMask(int len);
    logic [ML-1:0] m = '0;
    for (int i = 0; i < len; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: outWord=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic serialStep(output bit shifted);
    bit fb = 1'b0;
    for (int i = 0; i < mLen; i++) if (mTaps[i]) fb = fb ^ mState[i];
    shifted = mState[0];
    for (int i = 0; i < mLen - 1; i++) mState[i] = mState[i+1];
    mState[mLen-1] = fb;
  endtask

  // drive one cycle from a negedge, advance the model, compare at the next negedge
  task automatic cycle(string req, bit cw, int cl, logic [ML-1:0] ct,
                       bit sw, logic [ML-1:0] sd, bit en);
    cfgWe = cw; cfgLen = 9'(cl); cfgTaps = ct;
    seedWe = sw; seedData = sd; enable = en;
    if (cw && !en) begin
      mLen = (cl < 2) ? 2 : ((cl > ML) ? ML : cl);
      mTaps = ct & lowMask(mLen);
      mState = mState & lowMask(mLen);
    end
    if (sw) begin
      mState = sd & lowMask(mLen);
    end else if (en) begin
      for (int k = 0; k < NP; k++) begin
        bit b;
        serialStep(b);
        mOut[k] = b;
      end
    end
    @(negedge clk);
    cfgWe = 1'b0; seedWe = 1'b0; enable = 1'b0;
    check(req, outWord, mOut);
  endtask

  task automatic steps(string req, int n);
    for (int i = 0; i < n; i++) cycle(req, 0, 0, '0, 0, '0, 1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int lens[10] = '{2, 3, 5, 17, 32, 33, 64, 127, 255, 256};
    repeat (3) @(negedge clk);
    check("R1 reset output", outWord, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", outWord, '0);

    // R1: default length 256, zero taps: seed bits stream out, zeros enter
    cycle("R3 seed default length", 0, 0, '0, 1, rand256(), 0);
    steps("R1 default length and taps", 9);

    // R5/R6: hand-sized register
    cycle("R2 cfg len 5", 1, 5, 256'h12, 0, '0, 0);
    cycle("R3 seed len 5", 0, 0, '0, 1, 256'h1, 0);
    steps("R5 single-step rule", 4);

    // R6/R7: sweep of lengths and random taps, with idle gaps
    foreach (lens[j]) begin
      cycle("R2 cfg sweep", 1, lens[j], rand256(), 0, '0, 0);
      cycle("R3 seed sweep", 0, 0, '0, 1, rand256(), 0);
      for (int s = 0; s < 12; s++) begin
        cycle("R6 chained steps", 0, 0, '0, 0, '0, 1);
        if (s % 4 == 3) cycle("R8 idle hold", 0, 0, '0, 0, '0, 0);
      end
    end

    // R2: clamping
    cycle("R2 clamp low", 1, 0, rand256(), 0, '0, 0);
    cycle("R3 seed", 0, 0, '0, 1, rand256(), 0);
    steps("R2 len clamped to 2", 5);
    cycle("R2 clamp high", 1, 300, rand256(), 0, '0, 0);
    cycle("R3 seed", 0, 0, '0, 1, rand256(), 0);
    steps("R2 len clamped to 256", 5);

    // R2: configuration presented with enable is ignored
    cycle("R2 cfg while enabled", 1, 7, rand256(), 0, '0, 1);
    steps("R2 old config kept", 6);

    // R4: seed and enable together
    cycle("R4 seed with enable", 0, 0, '0, 1, rand256(), 1);
    steps("R4 stepping after seed", 4);
    cycle("R4 seed and cfg with enable", 1, 9, rand256(), 1, rand256(), 1);
    steps("R4 after combined", 3);

    // R3: config and seed same cycle, seed masked by new length
    cycle("R3 cfg+seed together", 1, 40, rand256(), 1, rand256(), 0);
    steps("R3 new length on seed", 6);

    // R10: shorten without reseeding
    cycle("R10 shrink", 1, 13, rand256(), 0, '0, 0);
    steps("R10 upper bits cleared", 6);

    // R9: zero seed
    cycle("R9 zero seed", 1, 100, rand256(), 1, '0, 0);
    steps("R9 zero stays zero", 5);

    // random mixed traffic
    for (int t = 0; t < 200; t++) begin
      int op = int'($urandom % 8);
      if (op == 0) cycle("R2 random cfg", 1, int'($urandom % 300), rand256(), 0, '0, 0);
      else if (op == 1) cycle("R3 random seed", 0, 0, '0, 1, rand256(), 0);
      else if (op == 2) cycle("R4 random seed+en", 0, 0, '0, 1, rand256(), 1);
      else if (op == 3) cycle("R8 random idle", 0, 0, '0, 0, '0, 0);
      else cycle("R6 random step", 0, 0, '0, 0, '0, 1);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule